// File: doc/BRIEF.md
# CAN Message Buffer Front-End

This block sits between a CAN bit-level protocol engine and a byte-wide message buffer memory holding fifteen eight-byte buffers. One 16-bit configuration register sets how it behaves. The register sets the pin polarity for the transmit and receive lines. It selects the order in which the eight data bytes are stored. It turns on locking of buffers after reception, and it turns on resynchronisation of the timestamp by buffer-0 traffic. Clearing its enable bit stops the block and clears only run-time state.

The protocol engine sends received bytes with a buffer number and a byte index, where index 0 is the first byte on the bus. It asks for transmit bytes the same way, by buffer and index. At the end of each frame it raises a one-cycle completion strobe. On a good completion the block updates the buffer's 4-bit status code and emits the current timestamp for storage. Software reaches the configuration, timestamp, error counters, overrun flags and per-buffer status codes through a simple register port. Register writes take effect at the next clock edge. Register reads are combinational.

Top module: `canbuf_front`

## Requirements
- R1: Register 0 holds the configuration: bit 0 enable, bit 1 transmit polarity, bit 2 receive polarity, bit 3 lock enable, bit 4 timestamp sync, bit 5 byte order. Bits 15:6 always read zero. The register resets to zero.
- R2: With the transmit polarity bit at 0, a dominant request drives `can_tx` low and a recessive request drives it high. With the bit at 1 both levels are inverted. While disabled, `can_tx` sits at the recessive level.
- R3: With the receive polarity bit at 0, a low `can_rx` is reported on `rx_dom` as dominant (1). With the bit at 1 the reading is inverted. While disabled, `rx_dom` reads 0.
- R4: Byte index i of buffer b maps to memory address b*8+i when the byte-order bit is 1, and to b*8+(7-i) when it is 0. The same mapping is used for received-byte writes (`mem_waddr`) and transmit-byte reads (`mem_raddr`). `tx_data` returns `mem_rdata`.
- R5: Status codes are EMPTY=0, RX_READY=1, RX_FULL=2 and TX_PENDING=3. Buffer b's status is read and written at register 16+b. A good receive completion sets RX_FULL, and a good transmit completion sets EMPTY. Either one pulses `ts_we` with the buffer number and the current timestamp. A completion flagged not-ok changes nothing, and so does a buffer number of 15 or above.
- R6: With lock enable set, a good reception locks its buffer. Received bytes for a locked buffer are not written, and a receive completion for it changes neither status nor timestamp output. Writing RX_READY into the buffer's status unlocks it.
- R7: With lock enable clear, no buffer locks, and any existing locks are dropped.
- R8: A receive completion that is rejected because the buffer is locked sets that buffer's bit in register 3. The bit stays set until software writes 1 to it.
- R9: The 16-bit timestamp at register 1 advances by one on each `bit_tick` while enabled, and wraps from 65535 to 0.
- R10: With timestamp sync set, a good completion on buffer 0, receive or transmit, resets the timestamp to 0. Completions on other buffers do not reset it, and neither does any completion while sync is clear.
- R11: While the enable bit is clear, the timestamp, both error counters and all locks are held at zero, and bytes, ticks and completions are ignored. The configuration, status codes and overrun flags keep their values.
- R12: Register 2 reads {receive error count, transmit error count}, 8 bits each. `err_rx_inc` and `err_tx_inc` add one per cycle, saturating at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bit_tick | input | 1 | Bit-time strobe for the timestamp |
| err_tx_inc | input | 1 | Transmit error count increment |
| err_rx_inc | input | 1 | Receive error count increment |
| tx_dom | input | 1 | Engine requests dominant on the bus |
| can_tx | output | 1 | Transmit pin |
| can_rx | input | 1 | Receive pin |
| rx_dom | output | 1 | Bus level seen as dominant |
| eng_run | output | 1 | Engine run enable (copy of enable bit) |
| rx_vld | input | 1 | Received byte valid |
| rx_buf | input | 4 | Buffer of received byte |
| rx_idx | input | 3 | Bus order index of received byte |
| rx_data | input | 8 | Received byte |
| tx_buf | input | 4 | Buffer of transmit byte |
| tx_idx | input | 3 | Bus order index of transmit byte |
| tx_data | output | 8 | Transmit byte |
| frm_done | input | 1 | Frame completion strobe |
| frm_tx | input | 1 | Completed frame was a transmission |
| frm_ok | input | 1 | Frame completed successfully |
| frm_buf | input | 4 | Buffer of completed frame |
| mem_we | output | 1 | Buffer memory write enable |
| mem_waddr | output | 7 | Buffer memory write address |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_raddr | output | 7 | Buffer memory read address |
| mem_rdata | input | 8 | Buffer memory read data |
| ts_we | output | 1 | Timestamp store strobe |
| ts_buf | output | 4 | Buffer of timestamp store |
| ts_val | output | 16 | Timestamp value to store |

## Verification
The assertions assume a completion strobe lasts one cycle and names a single buffer. They also assume that a status write to the same buffer in the same cycle is overridden by the completion. The stimulus never overlaps software status writes with completions on the same buffer. The error strobes are held only long enough to reach saturation. Every received byte and every completion is driven for exactly one cycle between negative edges, so the scoreboard can attribute each memory write to a single driven byte.

// File: rtl/canbuf_front.sv
module canbuf_front #(
  parameter int NBUF = 15,
  parameter int TSW  = 16,
  parameter int ECW  = 8,
  localparam int BW  = $clog2(NBUF + 1),
  localparam int AW  = BW + 3,
  localparam int RAW = BW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  input  logic           bit_tick,
  input  logic           err_tx_inc,
  input  logic           err_rx_inc,
  input  logic           tx_dom,
  output logic           can_tx,
  input  logic           can_rx,
  output logic           rx_dom,
  output logic           eng_run,
  input  logic           rx_vld,
  input  logic [BW-1:0]  rx_buf,
  input  logic [2:0]     rx_idx,
  input  logic [7:0]     rx_data,
  input  logic [BW-1:0]  tx_buf,
  input  logic [2:0]     tx_idx,
  output logic [7:0]     tx_data,
  input  logic           frm_done,
  input  logic           frm_tx,
  input  logic           frm_ok,
  input  logic [BW-1:0]  frm_buf,
  output logic           mem_we,
  output logic [AW-1:0]  mem_waddr,
  output logic [7:0]     mem_wdata,
  output logic [AW-1:0]  mem_raddr,
  input  logic [7:0]     mem_rdata,
  output logic           ts_we,
  output logic [BW-1:0]  ts_buf,
  output logic [TSW-1:0] ts_val
);
  localparam logic [3:0] ST_EMPTY = 4'd0;
  localparam logic [3:0] ST_RDY   = 4'd1;
  localparam logic [3:0] ST_FULL  = 4'd2;
  localparam int SB = 1 << BW;

  logic [5:0]      cfg;
  logic [3:0]      sts [NBUF];
  logic [NBUF-1:0] lock, ovr;
  logic [TSW-1:0]  ts_q;
  logic [ECW-1:0]  tec, rec;
  logic            rx_lk, done_lk, done_v, acc, rej, ts_clr;
  logic            unused_bits;

  wire en    = cfg[0];
  wire ctx   = cfg[1];
  wire crx   = cfg[2];
  wire lken  = cfg[3];
  wire tsync = cfg[4];
  wire ddir  = cfg[5];

  assign unused_bits = ^reg_wdata[15:6];

  assign eng_run = en;
  assign can_tx  = en ? (tx_dom ^ ~ctx) : ~ctx;
  assign rx_dom  = en & (can_rx ^ ~crx);

  always_comb begin
    rx_lk   = 1'b0;
    done_lk = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (rx_buf == BW'(i))  rx_lk   = lock[i];
      if (frm_buf == BW'(i)) done_lk = lock[i];
    end
  end

  assign mem_we    = en & rx_vld & (int'(rx_buf) < NBUF) & ~rx_lk;
  assign mem_waddr = {rx_buf, ddir ? rx_idx : ~rx_idx};
  assign mem_wdata = rx_data;
  assign mem_raddr = {tx_buf, ddir ? tx_idx : ~tx_idx};
  assign tx_data   = mem_rdata;

  assign done_v = en & frm_done & frm_ok & (int'(frm_buf) < NBUF);
  assign acc    = done_v & (frm_tx | ~done_lk);
  assign rej    = done_v & ~frm_tx & done_lk;
  assign ts_clr = tsync & acc & (frm_buf == '0);

  assign ts_we  = acc;
  assign ts_buf = frm_buf;
  assign ts_val = ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      ts_q <= '0;
      tec  <= '0;
      rec  <= '0;
      lock <= '0;
      ovr  <= '0;
      for (int i = 0; i < NBUF; i++) sts[i] <= ST_EMPTY;
    end else begin
      if (reg_we && reg_addr == RAW'(0)) cfg <= reg_wdata[5:0];

      if (!en)           ts_q <= '0;
      else if (ts_clr)   ts_q <= '0;
      else if (bit_tick) ts_q <= ts_q + 1'b1;

      if (!en) begin
        tec <= '0;
        rec <= '0;
      end else begin
        if (err_tx_inc && tec != '1) tec <= tec + 1'b1;
        if (err_rx_inc && rec != '1) rec <= rec + 1'b1;
      end

      for (int i = 0; i < NBUF; i++) begin
        if (reg_we && reg_addr == RAW'(SB + i)) begin
          sts[i] <= reg_wdata[3:0];
          if (reg_wdata[3:0] == ST_RDY) lock[i] <= 1'b0;
        end
        if (reg_we && reg_addr == RAW'(3) && reg_wdata[i]) ovr[i] <= 1'b0;
        if (acc && frm_buf == BW'(i)) begin
          sts[i] <= frm_tx ? ST_EMPTY : ST_FULL;
          if (!frm_tx && lken) lock[i] <= 1'b1;
        end
        if (rej && frm_buf == BW'(i)) ovr[i] <= 1'b1;
        if (!lken || !en) lock[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RAW'(0): reg_rdata = 16'(cfg);
      RAW'(1): reg_rdata = 16'(ts_q);
      RAW'(2): reg_rdata = 16'({rec, tec});
      RAW'(3): reg_rdata = 16'(ovr);
      default: begin
        for (int i = 0; i < NBUF; i++)
          if (reg_addr == RAW'(SB + i)) reg_rdata = 16'(sts[i]);
      end
    endcase
  end

  // R11: disabled block clears run-time state
  a_r11_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] |=> (ts_q == '0 && tec == '0 && rec == '0 && lock == '0));

  // R11: nothing reaches memory or timestamp store while disabled
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] |-> (!mem_we && !ts_we));

  // R6: a locked reception leaves its buffer locked
  a_r6_lock_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_we && !frm_tx && cfg[3]) |=> (((lock >> $past(frm_buf)) & NBUF'(1)) != '0));

  // R10: buffer-0 traffic resets the timestamp under sync
  a_r10_sync_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_we && cfg[4] && ts_buf == '0) |=> ts_q == '0);

  // R9: timestamp steps by one per tick
  a_r9_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && bit_tick && !ts_clr) |=> ts_q == TSW'($past(ts_q) + 1'b1));

  // R8: overrun flags are sticky without a clearing write
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RAW'(3)) |=> ((ovr & $past(ovr)) == $past(ovr)));
endmodule

// File: tb/canbuf_front_bench.sv
`timescale 1ns/100ps
module canbuf_front_bench;
  localparam real HALF = 2.5;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        bit_tick = 0, err_tx_inc = 0, err_rx_inc = 0;
  logic        tx_dom = 0, can_tx, can_rx = 0, rx_dom, eng_run;
  logic        rx_vld = 0;
  logic [3:0]  rx_buf = 0;
  logic [2:0]  rx_idx = 0;
  logic [7:0]  rx_data = 0;
  logic [3:0]  tx_buf = 0;
  logic [2:0]  tx_idx = 0;
  logic [7:0]  tx_data;
  logic        frm_done = 0, frm_tx = 0, frm_ok = 0;
  logic [3:0]  frm_buf = 0;
  logic        mem_we;
  logic [6:0]  mem_waddr, mem_raddr;
  logic [7:0]  mem_wdata, mem_rdata = 0;
  logic        ts_we;
  logic [3:0]  ts_buf;
  logic [15:0] ts_val;

  int nv = 0, nf = 0;
  logic [14:0] exp_q[$];

  always #HALF clk = ~clk;

  canbuf_front u_canbuf_front (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nv++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, input logic [15:0] e, input string tag);
    @(negedge clk); reg_addr = 5'(a); #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic rxb(input int b, input int i, input logic [7:0] d, input bit expw, input bit dd);
    if (expw) exp_q.push_back({7'(b * 8 + (dd ? i : 7 - i)), d});
    @(negedge clk); rx_vld = 1; rx_buf = 4'(b); rx_idx = 3'(i); rx_data = d;
    @(negedge clk); rx_vld = 0;
  endtask

  task automatic done(input int b, input bit tx, input bit ok, input bit ew,
                      input logic [15:0] tv, input string tag);
    @(negedge clk); frm_done = 1; frm_buf = 4'(b); frm_tx = tx; frm_ok = ok; #1;
    chk(tag, ts_we, ew);
    if (ew) begin
      chk(tag, ts_val, tv);
      chk(tag, ts_buf, 4'(b));
    end
    @(negedge clk); frm_done = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); bit_tick = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); bit_tick = 0;
  endtask

  // monitor: every memory write must match the next expected item
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && mem_we) begin
      nv++;
      if (exp_q.size() == 0) begin
        nf++;
        $display("FAIL R4/R6: unexpected write actual %0h:%0h expected none", mem_waddr, mem_wdata);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        if ({mem_waddr, mem_wdata} !== e) begin
          nf++;
          $display("FAIL R4: write actual %0h expected %0h", {mem_waddr, mem_wdata}, e);
        end
      end
    end
  end

  initial begin
    #(HALF * 2 * 200000);
    nf++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(0, 0, "R1");
    rd(1, 0, "R9");
    rd(18, 0, "R5");
    @(negedge clk); tx_dom = 1; can_rx = 0; #1;
    chk("R2 idle recessive", can_tx, 1);
    chk("R3 idle", rx_dom, 0);
    // disabled: everything ignored
    rxb(2, 0, 8'hAA, 0, 0);
    done(2, 0, 1, 0, 0, "R11 done ignored");
    rd(18, 0, "R11");
    ticks(3);
    rd(1, 0, "R11");
    // R1 reserved bits
    wr(0, 16'hFFC1);
    rd(0, 16'h0001, "R1");
    // R2/R3 polarity
    @(negedge clk); tx_dom = 1; can_rx = 0; #1;
    chk("R2 dom low", can_tx, 0);
    chk("R3 low dom", rx_dom, 1);
    @(negedge clk); tx_dom = 0; can_rx = 1; #1;
    chk("R2 rec high", can_tx, 1);
    chk("R3 high rec", rx_dom, 0);
    wr(0, 16'h0007);
    @(negedge clk); tx_dom = 1; can_rx = 1; #1;
    chk("R2 inverted", can_tx, 1);
    chk("R3 inverted", rx_dom, 1);
    wr(0, 16'h0001);
    // R4 descending order, R5 completion
    for (int i = 0; i < 8; i++) rxb(2, i, 8'(8'h10 + i), 1, 0);
    done(2, 0, 1, 1, 0, "R5 rx done");
    rd(18, 2, "R5 rx full");
    wr(0, 16'h0021);
    for (int i = 0; i < 8; i++) rxb(5, i, 8'(8'h50 + i), 1, 1);
    done(5, 0, 1, 1, 0, "R5 rx done asc");
    done(6, 0, 0, 0, 0, "R5 failed frame");
    rd(22, 0, "R5 failed no change");
    // R4 transmit read mapping
    @(negedge clk); tx_buf = 5; tx_idx = 2; mem_rdata = 8'h5A; #1;
    chk("R4 raddr asc", mem_raddr, 42);
    chk("R4 tx data", tx_data, 8'h5A);
    wr(0, 16'h0001);
    @(negedge clk); #1;
    chk("R4 raddr desc", mem_raddr, 45);
    wr(21, 3);
    rd(21, 3, "R5 tx pending");
    done(5, 1, 1, 1, 0, "R5 tx done");
    rd(21, 0, "R5 empty");
    done(15, 0, 1, 0, 0, "R5 no buffer 15");
    // R9 count
    ticks(10);
    rd(1, 10, "R9");
    // R6 lock
    wr(0, 16'h0009);
    rxb(3, 0, 8'h31, 1, 0);
    done(3, 0, 1, 1, 10, "R6 lock rx");
    rxb(3, 1, 8'h32, 0, 0);
    done(3, 0, 1, 0, 0, "R6 locked reject");
    rd(19, 2, "R6 status kept");
    rd(3, 16'h0008, "R8 overrun set");
    wr(19, 1);
    rd(19, 1, "R6 unlock");
    rxb(3, 2, 8'h33, 1, 0);
    done(3, 0, 1, 1, 10, "R6 relock");
    rd(3, 16'h0008, "R8 sticky");
    // R7 lock disabled
    wr(0, 16'h0001);
    rxb(3, 3, 8'h34, 1, 0);
    done(3, 0, 1, 1, 10, "R7 accepted");
    done(3, 0, 1, 1, 10, "R7 accepted again");
    wr(3, 16'h0008);
    rd(3, 0, "R8 clear");
    // R10 sync
    wr(0, 16'h0011);
    ticks(5);
    done(0, 0, 1, 1, 15, "R10 rx buf0");
    rd(1, 0, "R10 reset rx");
    ticks(4);
    done(0, 1, 1, 1, 4, "R10 tx buf0");
    rd(1, 0, "R10 reset tx");
    ticks(3);
    done(1, 0, 1, 1, 3, "R10 buf1");
    rd(1, 3, "R10 other buffer");
    wr(0, 16'h0001);
    done(0, 0, 1, 1, 3, "R10 sync off");
    rd(1, 3, "R10 no reset");
    // R9 wrap
    ticks(65536);
    rd(1, 3, "R9 wrap");
    // R12 error counters
    @(negedge clk); err_tx_inc = 1; err_rx_inc = 1;
    @(negedge clk); @(negedge clk); err_rx_inc = 0;
    @(negedge clk); err_tx_inc = 0;
    rd(2, 16'h0203, "R12 counts");
    @(negedge clk); err_tx_inc = 1;
    repeat (300) @(negedge clk);
    err_tx_inc = 0;
    rd(2, 16'h02FF, "R12 saturate");
    // R11 disable
    wr(0, 16'h0009);
    done(4, 0, 1, 1, 3, "R11 lock buf4");
    done(4, 0, 1, 0, 0, "R11 overrun buf4");
    wr(0, 16'h0008);
    rd(2, 0, "R11 counters cleared");
    rd(1, 0, "R11 ts cleared");
    rd(20, 2, "R11 status kept");
    rd(0, 16'h0008, "R11 cfg kept");
    rd(3, 16'h0010, "R11 overrun kept");
    wr(0, 16'h0009);
    rxb(4, 0, 8'h44, 1, 0);
    repeat (3) @(negedge clk);
    nv++;
    if (exp_q.size() != 0) begin
      nf++;
      $display("FAIL R4: actual %0d writes missing expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end
endmodule